// File: doc/BRIEF.md
# Burst Waveform Player

The block plays back one stored period of an arbitrary waveform to a DAC. Its lookup table holds the samples, and software loads it while the generator is stopped. Sine, ramp, triangle, half sine or any other shape is just a different set of table contents. Each time the sample-rate tick arrives, the table index steps forward by one. The index wraps to zero after the programmed last entry, and each wrap completes one period.

In burst mode a period counter stops playback after a programmed number of whole periods. A second counter then holds the DAC at a programmable idle code for a programmed number of ticks, and the next burst follows. A burst count of zero gives continuous playback. An active flag is high while table samples are on the output.

Top module: `burst_wavegen`

## Requirements
- R1: While `en_i` is low, `active_o` is 0 and `dac_o` equals `idle_code_i`. The index, period counter and gap counter return to zero, so the next enable starts at table entry 0.
- R2: A table write (`wr_en_i`) stores `wr_data_i` at `wr_addr_i` only while `en_i` is low. A write presented while `en_i` is high leaves the table unchanged.
- R3: While emitting, `dac_o` equals the table entry at the current index. The index starts at 0 and advances by one on each cycle with `tick_i` high. Between ticks the output holds its value.
- R4: The table length is `last_i + 1` entries. On the tick taken at index `last_i`, the index wraps to 0, and that wrap completes one period.
- R5: With `burst_cnt_i` = N > 0, exactly N whole periods (N × (`last_i`+1) ticks) are emitted. After that the block enters the gap.
- R6: During the gap, `active_o` is 0 and `dac_o` equals `idle_code_i`. The gap lasts exactly `gap_i` ticks, and emission then resumes at entry 0.
- R7: With `gap_i` = 0, bursts follow one another with no idle sample.
- R8: With `burst_cnt_i` = 0, output is continuous and no gap is ever entered.
- R9: While emitting, `active_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator run enable |
| tick_i | input | 1 | Sample-rate step enable |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | ADDR_W | Table write address |
| wr_data_i | input | DATA_W | Table write data |
| last_i | input | ADDR_W | Index of the last table entry (length − 1) |
| burst_cnt_i | input | BURST_W | Periods per burst, 0 = continuous |
| gap_i | input | GAP_W | Gap length in ticks |
| idle_code_i | input | DATA_W | DAC code held while idle |
| dac_o | output | DATA_W | DAC sample code |
| active_o | output | 1 | High while table samples are emitted |

## Verification
The bench uses the default parameters: a 256-entry table of 8-bit samples and 16-bit burst and gap counters. With these defaults a full-length table can wrap at index 255, and short tables of 3 and 4 entries can be combined with burst counts of 1 and 2 and gaps of 0 and 3. Every sample is compared against an arithmetic model of the burst-and-gap cycle. The tick is applied every cycle and also once every third cycle, so that holding between ticks is covered.

// File: rtl/burst_wavegen_pkg.sv
package burst_wavegen_pkg;
  typedef enum logic {ST_EMIT = 1'b0, ST_GAP = 1'b1} seq_state_e;
endpackage

// File: rtl/bwg_table.sv
module bwg_table #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_allow_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_allow_i && wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];

  AST_NO_WRITE_WHILE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_allow_i && wr_en_i) |=> mem_q[$past(wr_addr_i)] == $past(mem_q[wr_addr_i])); // R2
endmodule

// File: rtl/bwg_index.sv
module bwg_index #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic [ADDR_W-1:0] idx_o,
  output logic              wrap_o
);
  logic [ADDR_W-1:0] idx_q;

  assign wrap_o = (idx_q >= last_i);
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (!en_i)  idx_q <= '0;
    else if (step_i) idx_q <= wrap_o ? '0 : idx_q + 1'b1;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && wrap_o) |=> idx_q == '0); // R4
endmodule

// File: rtl/bwg_seq.sv
module bwg_seq
  import burst_wavegen_pkg::*;
#(
  parameter int BURST_W = 16,
  parameter int GAP_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic               wrap_i,
  input  logic [BURST_W-1:0] burst_cnt_i,
  input  logic [GAP_W-1:0]   gap_i,
  output seq_state_e         state_o
);
  seq_state_e         state_q;
  logic [BURST_W-1:0] per_q;
  logic [GAP_W-1:0]   gap_q;
  logic               last_per;

  assign last_per = (burst_cnt_i != '0) && (per_q == burst_cnt_i - 1'b1);
  assign state_o  = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_EMIT;
      per_q   <= '0;
      gap_q   <= '0;
    end else if (!en_i) begin
      state_q <= ST_EMIT;
      per_q   <= '0;
      gap_q   <= '0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_EMIT: if (wrap_i) begin
          if (burst_cnt_i == '0) begin
            per_q <= '0;
          end else if (last_per) begin
            per_q <= '0;
            gap_q <= '0;
            if (gap_i != '0) state_q <= ST_GAP;
          end else begin
            per_q <= per_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_q + 1'b1 >= gap_i) begin
            gap_q   <= '0;
            state_q <= ST_EMIT;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: state_q <= ST_EMIT;
      endcase
    end
  end

  AST_CONT_NEVER_GAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && burst_cnt_i == '0 && state_q == ST_EMIT) |=> state_q == ST_EMIT); // R8
endmodule

// File: rtl/burst_wavegen.sv
module burst_wavegen
  import burst_wavegen_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int BURST_W = 16,
  parameter int GAP_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  last_i,
  input  logic [BURST_W-1:0] burst_cnt_i,
  input  logic [GAP_W-1:0]   gap_i,
  input  logic [DATA_W-1:0]  idle_code_i,
  output logic [DATA_W-1:0]  dac_o,
  output logic               active_o
);
  logic [ADDR_W-1:0] idx;
  logic              wrap;
  logic [DATA_W-1:0] sample;
  seq_state_e        state;

  bwg_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
    .clk_i, .rst_ni,
    .wr_allow_i (!en_i),
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i  (idx),
    .rd_data_o  (sample)
  );

  bwg_index #(.ADDR_W(ADDR_W)) u_index (
    .clk_i, .rst_ni, .en_i,
    .step_i (tick_i && state == ST_EMIT),
    .last_i,
    .idx_o  (idx),
    .wrap_o (wrap)
  );

  bwg_seq #(.BURST_W(BURST_W), .GAP_W(GAP_W)) u_seq (
    .clk_i, .rst_ni, .en_i, .tick_i,
    .wrap_i  (wrap),
    .burst_cnt_i, .gap_i,
    .state_o (state)
  );

  assign active_o = en_i && (state == ST_EMIT);
  assign dac_o    = active_o ? sample : idle_code_i;

  AST_GAP_INDEX_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_GAP) |-> idx == '0); // R6
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (idx == '0 || en_i)); // R1
endmodule

// File: tb/burst_wavegen_tb_top.sv
module burst_wavegen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        en = 0, tick = 0, wr_en = 0;
  logic [7:0]  wr_addr = 0, wr_data = 0, last = 0, idle = 8'h80;
  logic [15:0] burst = 0, gap = 0;
  logic [7:0]  dac;
  logic        active;
  logic [7:0]  ref_mem [256];
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_wavegen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .last_i(last), .burst_cnt_i(burst), .gap_i(gap), .idle_code_i(idle),
    .dac_o(dac), .active_o(active)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_table(int seed);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      wr_en = 1; wr_addr = 8'(i); wr_data = 8'(i * 7 + seed);
      ref_mem[i] = 8'(i * 7 + seed);
    end
    @(negedge clk); wr_en = 0;
  endtask

  // Runs nsteps ticks, one every div cycles, checking each sample vs the burst model.
  task automatic run_seq(string req, int l, int b, int g, int nsteps, int div);
    int t = 0;
    @(negedge clk);
    last = 8'(l - 1); burst = 16'(b); gap = 16'(g); en = 1; tick = 0;
    for (int c = 0; c < nsteps * div; c++) begin
      int p, exp_d, exp_a;
      if (b == 0) begin p = t % l; exp_a = 1; end
      else begin
        p = t % (b * l + g);
        exp_a = (p < b * l) ? 1 : 0;
        p = p % l;
      end
      exp_d = exp_a ? ref_mem[p] : idle;
      #1;
      chk(req, dac, exp_d);
      chk(req, active, exp_a);
      tick = ((c + 1) % div == 0);
      @(negedge clk);
      if (tick) t++;
    end
    tick = 0; en = 0;
    @(negedge clk);
  endtask

  task automatic test_reset();
    #1; chk("R1 reset dac", dac, idle); chk("R1 reset active", active, 0);
  endtask

  task automatic test_disabled();
    en = 0; tick = 1; idle = 8'h3C;
    repeat (3) @(negedge clk);
    #1; chk("R1 disabled dac", dac, 8'h3C); chk("R1 disabled active", active, 0);
    tick = 0; idle = 8'h80;
  endtask

  task automatic test_write_blocked();
    @(negedge clk);
    last = 8'd3; burst = 0; gap = 0; en = 1; tick = 1;
    wr_en = 1; wr_addr = 8'd2; wr_data = ~ref_mem[2];
    @(negedge clk); wr_en = 0;
    // idx now 1; next sample is entry 2
    @(negedge clk); #1;
    chk("R2 write ignored while running", dac, ref_mem[2]);
    tick = 0; en = 0;
    @(negedge clk);
  endtask

  task automatic test_full_wrap();
    @(negedge clk);
    last = 8'd255; burst = 0; en = 1; tick = 1;
    repeat (255) @(negedge clk);
    #1; chk("R4 index 255", dac, ref_mem[255]);
    @(negedge clk); #1; chk("R4 wrap to 0", dac, ref_mem[0]);
    tick = 0; en = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    load_table(5);
    test_disabled();
    run_seq("R3 R8 R9 continuous", 4, 0, 0, 20, 1);
    run_seq("R3 tick held every 3rd", 4, 0, 0, 10, 3);
    run_seq("R5 R6 burst 2 gap 3", 3, 2, 3, 30, 1);
    run_seq("R7 burst 1 gap 0", 3, 1, 0, 12, 1);
    run_seq("R5 R6 burst 1 gap 3 slow", 4, 1, 3, 16, 2);
    test_write_blocked();
    test_full_wrap();
    run_seq("R1 restart at entry 0", 3, 2, 3, 4, 1);
    load_table(9);
    run_seq("R2 write while stopped", 4, 0, 0, 8, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule